// File: doc/BRIEF.md
# Fixed-Window Cycle Interrupt Timer

This block counts bus clock cycles and holds an interrupt request high for a fixed band of counts. Software controls it through a single bit of a decoded register write: clearing the bit starts the count, setting it stops the count, zeroes the counter and withdraws any request in flight. No reload value, no compare register and no acknowledge access exist; the band edges are fixed parameters.

The clock input is the cycle strobe of the CPU bus, arranged so that its rising edge is the point where the bus clock falls; every such edge advances the count by one while running. The request output is registered and active high, ready for an inverter that pulls an open-drain line. Once started, the counter runs past the end of the band and rolls over at its full width, so the request comes back every 65536 cycles until software stops it.

Top module: `win_irq_timer`

## Requirements
- R1: After reset the timer is stopped: `irq_req` is 0 and stays 0 with no write, however many cycles pass.
- R2: Only bit 2 of `ctl_wdata` matters on a write with `ctl_we` high; every other data bit has no effect, and nothing changes while `ctl_we` is low.
- R3: A write with bit 2 equal to 0 starts the count; the write edge itself is count 1 and each later clock edge adds one.
- R4: `irq_req` goes to 1 on the edge where the count becomes 23680 (the 23680th edge counting the start write).
- R5: `irq_req` returns to 0 by itself on the edge where the count becomes 24320, so it is high for exactly 640 edges.
- R6: A write with bit 2 equal to 1 stops the count, forces `irq_req` to 0 on that write edge and clears the counter, so a later start measures the full 23680 edges again.
- R7: A further start write while the timer runs neither restarts nor disturbs the count.
- R8: The 16-bit counter wraps from 65535 to 0 while running, and `irq_req` rises again 65536 edges after its previous rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Cycle clock; rising edge marks the falling edge of the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| ctl_we | input | 1 | One-cycle strobe for a decoded write to the control register |
| ctl_wdata | input | 8 | Write data; bit 2 is the stop bit |
| irq_req | output | 1 | Registered, active-high interrupt request |

## Verification
The assertions take for granted that `ctl_we` and `ctl_wdata` are stable around the rising clock edge and carry no unknown values once reset is released, and that writes arrive only after the reset synchronizer has let go. The bench drives every input on the falling edge, waits three edges after releasing reset before its first write, and keeps each strobe to a single cycle, so the checker's view of start, stop and the band edges always follows the defined count.

// File: rtl/win_irq_timer_pkg.sv
package win_irq_timer_pkg;

  localparam int unsigned DEF_CNT_W   = 16;
  localparam int unsigned DEF_DATA_W  = 8;
  localparam int unsigned DEF_STOP_BIT = 2;
  localparam int unsigned DEF_BAND_LO = 23680;
  localparam int unsigned DEF_BAND_HI = 24320;

  typedef enum logic {
    TMR_RUN  = 1'b0,
    TMR_HALT = 1'b1
  } tmr_mode_e;

endpackage

// File: rtl/win_irq_timer_rst_sync.sv
module win_irq_timer_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/win_irq_timer_ctl.sv
module win_irq_timer_ctl
  import win_irq_timer_pkg::*;
#(
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned STOP_BIT = DEF_STOP_BIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [DATA_W-1:0] ctl_wdata,
  output tmr_mode_e         mode_d,
  output tmr_mode_e         mode_q
);

  logic mode_en;

  always_comb begin
    mode_en = ctl_we;
    mode_d  = mode_q;
    if (mode_en) begin
      mode_d = ctl_wdata[STOP_BIT] ? TMR_HALT : TMR_RUN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= TMR_HALT;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

endmodule

// File: rtl/win_irq_timer_count.sv
module win_irq_timer_count
  import win_irq_timer_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmr_mode_e        mode_d,
  output logic [CNT_W-1:0] cnt_d,
  output logic [CNT_W-1:0] cnt_q
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic cnt_en;

  always_comb begin
    cnt_en = (mode_d == TMR_RUN) || (cnt_q != '0);
    if (mode_d == TMR_HALT) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/win_irq_timer_band.sv
module win_irq_timer_band
  import win_irq_timer_pkg::*;
#(
  parameter int unsigned CNT_W   = DEF_CNT_W,
  parameter int unsigned BAND_LO = DEF_BAND_LO,
  parameter int unsigned BAND_HI = DEF_BAND_HI
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmr_mode_e        mode_d,
  input  logic [CNT_W-1:0] cnt_d,
  output logic             irq_q
);

  localparam logic [CNT_W-1:0] LO_VAL = CNT_W'(BAND_LO);
  localparam logic [CNT_W-1:0] HI_VAL = CNT_W'(BAND_HI);

  logic hit_lo;
  logic hit_hi;
  logic irq_d;
  logic irq_en;

  always_comb begin
    hit_lo = (cnt_d == LO_VAL);
    hit_hi = (cnt_d == HI_VAL);
    irq_d  = irq_q;
    if (mode_d == TMR_HALT) begin
      irq_d = 1'b0;
    end else if (hit_hi) begin
      irq_d = 1'b0;
    end else if (hit_lo) begin
      irq_d = 1'b1;
    end
    irq_en = (irq_d != irq_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else if (irq_en) begin
      irq_q <= irq_d;
    end
  end

endmodule

// File: rtl/win_irq_timer.sv
module win_irq_timer
  import win_irq_timer_pkg::*;
#(
  parameter int unsigned CNT_W    = DEF_CNT_W,
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned STOP_BIT = DEF_STOP_BIT,
  parameter int unsigned BAND_LO  = DEF_BAND_LO,
  parameter int unsigned BAND_HI  = DEF_BAND_HI
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [DATA_W-1:0] ctl_wdata,
  output logic              irq_req
);

  logic             rst_sync_n;
  tmr_mode_e        mode_d;
  tmr_mode_e        mode_q;
  logic             halt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] cnt_q;

  win_irq_timer_rst_sync #(
    .STAGES (2)
  ) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  win_irq_timer_ctl #(
    .DATA_W   (DATA_W),
    .STOP_BIT (STOP_BIT)
  ) u_ctl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .mode_d    (mode_d),
    .mode_q    (mode_q)
  );

  win_irq_timer_count #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .mode_d (mode_d),
    .cnt_d  (cnt_d),
    .cnt_q  (cnt_q)
  );

  win_irq_timer_band #(
    .CNT_W   (CNT_W),
    .BAND_LO (BAND_LO),
    .BAND_HI (BAND_HI)
  ) u_band (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .mode_d (mode_d),
    .cnt_d  (cnt_d),
    .irq_q  (irq_req)
  );

  assign halt_q = (mode_q == TMR_HALT);

endmodule

// File: rtl/win_irq_timer_chk.sv
module win_irq_timer_chk
  import win_irq_timer_pkg::*;
#(
  parameter int unsigned CNT_W    = DEF_CNT_W,
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned STOP_BIT = DEF_STOP_BIT,
  parameter int unsigned BAND_LO  = DEF_BAND_LO,
  parameter int unsigned BAND_HI  = DEF_BAND_HI
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              ctl_we,
  input logic [DATA_W-1:0] ctl_wdata,
  input logic              halt_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              irq_req
);

  localparam logic [CNT_W-1:0] LO_VAL  = CNT_W'(BAND_LO);
  localparam logic [CNT_W-1:0] HI_VAL  = CNT_W'(BAND_HI);
  localparam logic [CNT_W-1:0] ONE_VAL = CNT_W'(1);

  AST_STOP_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctl_we && ctl_wdata[STOP_BIT]) |=> (!irq_req && halt_q && cnt_q == '0)); // R6

  AST_START_AT_ONE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctl_we && !ctl_wdata[STOP_BIT]) |=> (!halt_q && cnt_q != '0)); // R3

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!halt_q && $past(!halt_q)) |-> (cnt_q == $past(cnt_q) + ONE_VAL)); // R8

  AST_RISE_AT_LO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(irq_req) |-> (cnt_q == LO_VAL)); // R4

  AST_FALL_AT_HI: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(irq_req) |-> ((cnt_q == HI_VAL) || halt_q)); // R5

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    halt_q |-> (!irq_req && cnt_q == '0)); // R1

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ctl_we && halt_q) |=> halt_q); // R2

endmodule

bind win_irq_timer win_irq_timer_chk u_chk (.*);

// File: tb/sim_win_irq_timer.sv
`timescale 1ns/1ps
module sim_win_irq_timer;

  localparam int LO = 23680;
  localparam int HI = 24320;
  localparam int WRAP = 65536;

  logic       clk;
  logic       rst_n;
  logic       ctl_we;
  logic [7:0] ctl_wdata;
  logic       irq_req;

  int n_checks;
  int n_fail;
  int edges;
  bit done;

  win_irq_timer u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .irq_req   (irq_req)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check_irq(input logic exp, input string req, input string what);
    n_checks++;
    if (irq_req !== exp) begin
      n_fail++;
      $display("FAIL %s %s: irq_req actual=%0b expected=%0b (edge %0d)", req, what, irq_req, exp, edges);
    end
  endtask

  // advance one edge, return at the following falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    edges++;
  endtask

  task automatic run_to(input int target);
    while (edges < target) step();
  endtask

  task automatic write_ctl(input logic [7:0] d);
    ctl_we    = 1'b1;
    ctl_wdata = d;
    step();
    ctl_we    = 1'b0;
    ctl_wdata = 8'h00;
  endtask

  task automatic do_reset();
    ctl_we    = 1'b0;
    ctl_wdata = 8'h00;
    rst_n     = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // R1: idle after reset; R2: writes with stop bit set keep it idle
  task automatic t_reset_idle();
    do_reset();
    edges = 0;
    check_irq(1'b0, "R1", "after reset");
    write_ctl(8'hFF);
    run_to(HI + 80);
    check_irq(1'b0, "R1", "no start, past band");
    ctl_wdata = 8'h00;
    run_to(HI + 100);
    check_irq(1'b0, "R2", "data without strobe ignored");
  endtask

  // R3 R4 R5 R7 R8: full band, restart write mid-run, wrap
  task automatic t_band_and_wrap();
    do_reset();
    edges = 0;
    write_ctl(8'hFB);            // bit 2 clear, others set: start (R2)
    check_irq(1'b0, "R3", "just started");
    run_to(99);
    write_ctl(8'h00);            // edge 100, further start (R7)
    run_to(LO - 1);
    check_irq(1'b0, "R7", "count undisturbed, before band");
    step();
    check_irq(1'b1, "R4", "band start");
    run_to(HI - 1);
    check_irq(1'b1, "R5", "last band edge");
    step();
    check_irq(1'b0, "R5", "band end");
    run_to(WRAP + LO - 1);
    check_irq(1'b0, "R8", "before band after wrap");
    step();
    check_irq(1'b1, "R8", "band after wrap");
    write_ctl(8'h04);
    check_irq(1'b0, "R6", "stop inside band");
  endtask

  // R6: stop mid-band clears counter; restart measures full interval
  task automatic t_stop_restart();
    do_reset();
    edges = 0;
    write_ctl(8'h00);
    run_to(LO + 10);
    check_irq(1'b1, "R4", "in band before stop");
    write_ctl(8'h04);
    check_irq(1'b0, "R6", "stop acknowledges");
    run_to(LO + 600);
    check_irq(1'b0, "R6", "stays low while stopped");
    edges = 0;
    write_ctl(8'h00);
    run_to(LO - 1);
    check_irq(1'b0, "R6", "restart counts from zero");
    step();
    check_irq(1'b1, "R6", "restart reaches band");
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    edges    = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    ctl_we   = 1'b0;
    ctl_wdata = 8'h00;
    t_reset_idle();
    t_band_and_wrap();
    t_stop_restart();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule